// File: doc/BRIEF.md
# Shared Timer Prescaler with Pin-Clock Synchronizer

This block produces the count-enable strobes for two timer/counters that share a single prescaler. A free-running 10-bit prescale counter advances on every system clock. Each timer has a 3-bit clock-select input. The select chooses one of five sources: no clock at all, every system clock, one of four divided taps of the shared counter, or an edge of that timer's own external pin. Each timer output is a single-cycle enable pulse that is high for the cycle in which the timer should advance.

External pins are not divided. Each pin goes through a two-stage synchronizer and then an edge-detect flop, and the detected edge becomes the tick directly. A pin is only seen correctly if it stays at each level for longer than one system clock cycle, so its frequency has to stay below half the system clock. Software can restart the shared prescale counter by writing a one to a control bit. That bit clears itself after one cycle, always reads as zero, and moves the tap phase of both timers together. Writing a zero to it does nothing. The pin synchronizers keep running while a prescaler restart is in progress.

There are no streaming data paths. All pins are plain control and status signals, and none of them carries a valid/ready handshake.

Top module: `tmr_psc`

## Requirements
- R1: While reset is asserted both ticks are low and the prescale count is zero. After reset is released, the count advances by one on every rising clock edge, so a timer with select 2 (divide by 8) first ticks in the cycle after the seventh edge.
- R2: A select value of 0 holds that timer's tick low in every cycle.
- R3: A select value of 1 holds that timer's tick high in every cycle.
- R4: Select values 2, 3, 4 and 5 raise the tick for exactly the cycles in which the low 3, 6, 8 or 10 bits of the shared count are all ones. This gives periods of 8, 64, 256 and 1024 cycles.
- R5: A write (`psr_wr` high) with `psr_wdata` = 1 sets a pending flag on the next edge. The edge after that loads the shared count with zero. Both timers' tap ticks are masked while the flag is set.
- R6: A write with `psr_wdata` = 0 leaves the count and both ticks exactly as they would have been without the write.
- R7: `psr_rdata` reads zero in every cycle, including during a write of one.
- R8: The pending flag clears itself one cycle after it is set unless another write of one arrives. A single write therefore causes exactly one restart, and counting resumes afterwards.
- R9: Select 6 gives a single-cycle tick for each falling edge of that timer's pin, and ignores rising edges. The tick goes high after the second rising clock edge that samples the new pin level.
- R10: Select 7 gives a single-cycle tick for each rising edge of the pin, with the same latency as R9, and ignores falling edges.
- R11: A prescaler restart does not delay, drop or add any pin-clocked tick.
- R12: The two timers choose their sources independently. A restart affects the tap timing of both timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psr_wr | input | 1 | Write strobe for the prescaler-restart bit |
| psr_wdata | input | 1 | Value written; 1 requests a restart |
| psr_rdata | output | 1 | Read value of the restart bit (always 0) |
| sel_t0 | input | 3 | Clock select, timer 0 |
| sel_t1 | input | 3 | Clock select, timer 1 |
| pin_t0 | input | 1 | External clock pin, timer 0 (asynchronous) |
| pin_t1 | input | 1 | External clock pin, timer 1 (asynchronous) |
| tick_t0 | output | 1 | Count enable, timer 0 |
| tick_t1 | output | 1 | Count enable, timer 1 |

## Verification
The following properties are checked on every cycle:
- A stopped select stays silent.
- The undivided select is always high.
- The read value stays zero.
- The count steps by one unless a restart is pending.
- A pending restart both empties the counter and releases itself.
- Tap and pin ticks never last two cycles under a steady select.
- The divide-by-1024 tick coincides with an all-ones count.

Some behaviour needs known stimulus history and only the bench's scenarios can show it:
- The exact cycle at which each tap first fires after reset or after a restart.
- The two-edge latency from a pin change to its tick.
- That pin ticks are undisturbed by a coincident restart.
- That the opposite pin edge is ignored.

// File: rtl/tmr_psc_pkg.sv
package tmr_psc_pkg;

  localparam int SEL_W  = 3;
  localparam int NUM_TAPS = 4;

  typedef enum logic [SEL_W-1:0] {
    CS_STOP     = 3'd0,
    CS_SYS      = 3'd1,
    CS_DIV_A    = 3'd2,
    CS_DIV_B    = 3'd3,
    CS_DIV_C    = 3'd4,
    CS_DIV_D    = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } clk_sel_e;

  // number of low count bits that must be all ones for tap i
  function automatic int tap_bits(input int i);
    case (i)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/tmr_psc_counter.sv
module tmr_psc_counter #(
  parameter int CNT_W  = 10,
  parameter int N_TAPS = tmr_psc_pkg::NUM_TAPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_req,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              pend_o,
  output logic [N_TAPS-1:0] tap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= clr_req;
      if (pend_q) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    localparam int B = tmr_psc_pkg::tap_bits(g);
    assign tap_o[g] = (&cnt_q[B-1:0]) & ~pend_q;
  end

  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/tmr_psc_extsync.sv
module tmr_psc_extsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              edge_q;
  logic              lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      edge_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      edge_q <= sync_q[STAGES-1];
    end
  end

  assign lvl    = sync_q[STAGES-1];
  assign rise_o = lvl & ~edge_q;
  assign fall_o = ~lvl & edge_q;

endmodule

// File: rtl/tmr_psc_tick_mux.sv
module tmr_psc_tick_mux
  import tmr_psc_pkg::*;
#(
  parameter int N_TAPS = NUM_TAPS
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [N_TAPS-1:0] tap,
  input  logic              ext_rise,
  input  logic              ext_fall,
  output logic              tick
);

  localparam int FIRST_DIV = int'(CS_DIV_A);

  int idx;

  always_comb begin
    idx  = int'(sel) - FIRST_DIV;
    tick = 1'b0;
    case (clk_sel_e'(sel))
      CS_STOP:     tick = 1'b0;
      CS_SYS:      tick = 1'b1;
      CS_EXT_FALL: tick = ext_fall;
      CS_EXT_RISE: tick = ext_rise;
      default: begin
        for (int i = 0; i < N_TAPS; i++)
          if (idx == i) tick = tap[i];
      end
    endcase
  end

endmodule

// File: rtl/tmr_psc.sv
module tmr_psc
  import tmr_psc_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psr_wr,
  input  logic             psr_wdata,
  output logic             psr_rdata,
  input  logic [SEL_W-1:0] sel_t0,
  input  logic [SEL_W-1:0] sel_t1,
  input  logic             pin_t0,
  input  logic             pin_t1,
  output logic             tick_t0,
  output logic             tick_t1
);

  localparam int N_TMR = 2;

  logic [CNT_W-1:0]    pres_cnt;
  logic                psr_pend;
  logic [NUM_TAPS-1:0] taps;
  logic [SEL_W-1:0]    sel_a  [N_TMR];
  logic                pin_a  [N_TMR];
  logic                tick_a [N_TMR];

  assign sel_a[0] = sel_t0;
  assign sel_a[1] = sel_t1;
  assign pin_a[0] = pin_t0;
  assign pin_a[1] = pin_t1;
  assign tick_t0  = tick_a[0];
  assign tick_t1  = tick_a[1];
  assign psr_rdata = 1'b0;

  tmr_psc_counter #(.CNT_W(CNT_W), .N_TAPS(NUM_TAPS)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_req (psr_wr & psr_wdata),
    .cnt_o   (pres_cnt),
    .pend_o  (psr_pend),
    .tap_o   (taps)
  );

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    logic rise, fall;

    tmr_psc_extsync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin    (pin_a[t]),
      .rise_o (rise),
      .fall_o (fall)
    );

    tmr_psc_tick_mux #(.N_TAPS(NUM_TAPS)) u_mux (
      .sel      (sel_a[t]),
      .tap      (taps),
      .ext_rise (rise),
      .ext_fall (fall),
      .tick     (tick_a[t])
    );
  end

endmodule

// File: rtl/tmr_psc_chk.sv
module tmr_psc_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             psr_wr,
  input logic             psr_wdata,
  input logic             psr_rdata,
  input logic [2:0]       sel_t0,
  input logic [2:0]       sel_t1,
  input logic             tick_t0,
  input logic             tick_t1,
  input logic [CNT_W-1:0] pres_cnt,
  input logic             psr_pend
);

  assert_stop_quiet_t0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_t0 == 3'd0) |-> !tick_t0);
  assert_stop_quiet_t1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_t1 == 3'd0) |-> !tick_t1);

  assert_sys_always_t0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_t0 == 3'd1) |-> tick_t0);
  assert_sys_always_t1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_t1 == 3'd1) |-> tick_t1);

  assert_tap_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_t0 >= 3'd2 && sel_t0 <= 3'd5 && tick_t0) |=> (sel_t0 != $past(sel_t0) || !tick_t0));
  assert_tap_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_t0 == 3'd5 && tick_t0) |-> (&pres_cnt));

  assert_clr_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_wr && psr_wdata) |=> ##1 (pres_cnt == '0));

  assert_count_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !psr_pend |=> (pres_cnt == $past(pres_cnt) + 1'b1));

  assert_rd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    psr_rdata == 1'b0);

  assert_self_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_pend && !(psr_wr && psr_wdata)) |=> !psr_pend);

  assert_fall_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_t0 == 3'd6 && tick_t0) |=> (sel_t0 != 3'd6 || !tick_t0));
  assert_rise_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_t1 == 3'd7 && tick_t1) |=> (sel_t1 != 3'd7 || !tick_t1));

endmodule

bind tmr_psc tmr_psc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .psr_wr    (psr_wr),
  .psr_wdata (psr_wdata),
  .psr_rdata (psr_rdata),
  .sel_t0    (sel_t0),
  .sel_t1    (sel_t1),
  .tick_t0   (tick_t0),
  .tick_t1   (tick_t1),
  .pres_cnt  (pres_cnt),
  .psr_pend  (psr_pend)
);

// File: tb/tmr_psc_tb.sv
module tmr_psc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       psr_wr = 1'b0;
  logic       psr_wdata = 1'b0;
  logic       psr_rdata;
  logic [2:0] sel_t0 = 3'd0;
  logic [2:0] sel_t1 = 3'd0;
  logic       pin_t0 = 1'b0;
  logic       pin_t1 = 1'b0;
  logic       tick_t0, tick_t1;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model of the shared count, built from R1, R5, R6, R8
  int mcnt  = 0;
  bit mpend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt  <= 0;
      mpend <= 1'b0;
    end else begin
      mpend <= psr_wr && psr_wdata;
      mcnt  <= mpend ? 0 : (mcnt + 1) % 1024;
    end
  end

  tmr_psc u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .psr_wr    (psr_wr),
    .psr_wdata (psr_wdata),
    .psr_rdata (psr_rdata),
    .sel_t0    (sel_t0),
    .sel_t1    (sel_t1),
    .pin_t0    (pin_t0),
    .pin_t1    (pin_t1),
    .tick_t0   (tick_t0),
    .tick_t1   (tick_t1)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit tap_exp(input logic [2:0] s);
    int bits;
    int div;
    case (s)
      3'd2: bits = 3;
      3'd3: bits = 6;
      3'd4: bits = 8;
      default: bits = 10;
    endcase
    div = 1 << bits;
    return ((mcnt % div) == div - 1) && !mpend;
  endfunction

  task automatic t_reset();
    sel_t0 = 3'd2;
    sel_t1 = 3'd0;
    repeat (3) @(negedge clk);
    chk("R1 tick_t0 in reset", tick_t0, 0);
    chk("R1 tick_t1 in reset", tick_t1, 0);
    rst_n = 1'b1;
    for (int n = 1; n <= 8; n++) begin
      @(negedge clk);
      if (n < 7) chk("R1 no early div8 tick", tick_t0, 0);
      if (n == 7) chk("R1 first div8 tick", tick_t0, 1);
      if (n == 8) chk("R1 div8 tick one cycle", tick_t0, 0);
    end
    chk("R7 rdata after reset", psr_rdata, 0);
  endtask

  task automatic t_stop_sys();
    int bad0 = 0;
    int bad1 = 0;
    sel_t0 = 3'd0;
    sel_t1 = 3'd1;
    repeat (60) begin
      @(negedge clk);
      if (tick_t0 !== 1'b0) bad0++;
      if (tick_t1 !== 1'b1) bad1++;
    end
    chk("R2 stopped select ticks", bad0, 0);
    chk("R3 system select misses", bad1, 0);
  endtask

  task automatic t_taps();
    for (int s = 2; s <= 5; s++) begin
      int bad = 0;
      int cnt0 = 0;
      sel_t0 = 3'(s);
      sel_t1 = 3'(7 - s);
      repeat (2100) begin
        @(negedge clk);
        if (tick_t0 !== tap_exp(sel_t0)) bad++;
        if (tick_t1 !== tap_exp(sel_t1)) bad++;
        if (tick_t0) cnt0++;
      end
      chk($sformatf("R4 R12 tap mismatches sel=%0d", s), bad, 0);
      chk($sformatf("R4 tick count sel=%0d", s), cnt0 > 0, 1);
    end
  endtask

  task automatic t_restart();
    int first0 = 0;
    int second0 = 0;
    int first1 = 0;
    sel_t0 = 3'd2;
    sel_t1 = 3'd3;
    @(negedge clk);
    psr_wr = 1'b1;
    psr_wdata = 1'b1;
    #1 chk("R7 rdata during write", psr_rdata, 0);
    for (int n = 1; n <= 70; n++) begin
      @(negedge clk);
      psr_wr = 1'b0;
      psr_wdata = 1'b0;
      if (tick_t0 && first0 == 0) first0 = n;
      else if (tick_t0 && second0 == 0) second0 = n;
      if (tick_t1 && first1 == 0) first1 = n;
    end
    chk("R5 timer0 first tick after restart", first0, 9);
    chk("R8 timer0 counting resumes", second0, 17);
    chk("R12 timer1 also restarted", first1, 65);
  endtask

  task automatic t_write_zero();
    int bad = 0;
    sel_t0 = 3'd2;
    sel_t1 = 3'd3;
    @(negedge clk);
    psr_wr = 1'b1;
    psr_wdata = 1'b0;
    repeat (100) begin
      @(negedge clk);
      psr_wr = 1'b0;
      if (tick_t0 !== tap_exp(3'd2)) bad++;
      if (tick_t1 !== tap_exp(3'd3)) bad++;
    end
    chk("R6 zero write leaves ticks", bad, 0);
  endtask

  task automatic t_ext();
    sel_t0 = 3'd6;
    sel_t1 = 3'd7;
    repeat (4) @(negedge clk);
    pin_t0 = 1'b1;
    pin_t1 = 1'b1;
    @(negedge clk);
    chk("R10 no tick before latency", tick_t1, 0);
    @(negedge clk);
    chk("R10 rise tick", tick_t1, 1);
    chk("R9 rise ignored by fall select", tick_t0, 0);
    @(negedge clk);
    chk("R10 rise tick single cycle", tick_t1, 0);
    repeat (3) @(negedge clk);
    pin_t0 = 1'b0;
    pin_t1 = 1'b0;
    @(negedge clk);
    chk("R9 no tick before latency", tick_t0, 0);
    @(negedge clk);
    chk("R9 fall tick", tick_t0, 1);
    chk("R10 fall ignored by rise select", tick_t1, 0);
    @(negedge clk);
    chk("R9 fall tick single cycle", tick_t0, 0);
    // restart written together with a pin edge
    repeat (3) @(negedge clk);
    pin_t1 = 1'b1;
    psr_wr = 1'b1;
    psr_wdata = 1'b1;
    @(negedge clk);
    psr_wr = 1'b0;
    psr_wdata = 1'b0;
    chk("R11 no early pin tick", tick_t1, 0);
    @(negedge clk);
    chk("R11 pin tick kept through restart", tick_t1, 1);
    @(negedge clk);
    chk("R11 pin tick not repeated", tick_t1, 0);
  endtask

  initial begin
    t_reset();
    t_stop_sys();
    t_taps();
    t_restart();
    t_write_zero();
    t_ext();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule